// File: doc/BRIEF.md
# Stack-Addressed Accumulator Processor Core

This block is a small 16-bit processor built around one accumulator, a program counter and a stack pointer. It reads instructions one word at a time from a single-port synchronous memory of 4096 sixteen-bit words, with a read latency of one cycle. Its instruction set covers loads, stores and arithmetic on absolute addresses, loads and stores relative to the stack pointer, a load of a small constant, conditional and unconditional branches, a subroutine call and return, stack pushes and pops (including indirect forms that go through the accumulator), an exchange of accumulator and stack pointer, and immediate adjustments of the stack pointer.

The core comes out of reset halted. While it is halted, a debug port can preload PC, SP and AC, and the current values of all three are always visible on observation outputs. A start pulse leaves the halted state and fetching begins at the current PC. The core halts again on the halt instruction or on any word that decodes to no instruction. Each instruction takes a fetch cycle, a decode cycle, an address/execute cycle and, where memory data has to be read, one or two further cycles.

Top module: `stk_core`

## Requirements
- R1: After reset the core is halted (`halted` = 1) and PC, SP and AC all read zero.
- R2: While halted, `dbgLoadPc`, `dbgLoadSp` and `dbgLoadAc` copy `dbgData` (its low 12 bits for PC) into that register; a `start` pulse leaves the halted state and fetch begins at the PC, including a PC loaded in the same cycle as `start`. Debug loads issued while running have no effect.
- R3: Top nibble 0 loads AC from the 12-bit address in the low bits, 1 stores AC there, 2 adds that word to AC, 3 subtracts it from AC, and 7 loads the 12-bit operand zero-extended into AC. Arithmetic wraps modulo 2^16.
- R4: Branches take the low 12 bits as target: nibble 4 when AC bit 15 is 0, 5 when AC is zero, 6 always, C when AC bit 15 is 1, D when AC is nonzero. Untaken branches continue at the next word.
- R5: Nibbles 8, 9, A and B load, store, add and subtract like nibbles 0 to 3 but at address (SP + operand) reduced to its low 12 bits; SP is 16 bits wide and only its low 12 bits form addresses.
- R6: Nibble E decrements SP, stores the already advanced PC at SP and jumps to the operand. Word F800 loads PC from the word at SP and then increments SP. Word F400 decrements SP then stores AC at SP; word F600 loads AC from the word at SP then increments SP.
- R7: Word F000 decrements SP then stores at SP the word read from address AC. Word F200 reads the word at SP, increments SP and writes that word to address AC.
- R8: Word FA00 exchanges AC and SP; words FCnn add nn to SP and FEnn subtract nn from SP, modulo 2^16.
- R9: Any word FFnn halts the core, and so does any word in the F group that matches none of the encodings above (including F0 to FA groups with a nonzero low byte); PC is left one past the halting word and no other state changes.
- R10: A minimum-of-three subroutine called with three pushed arguments, started with PC at 0x50 and SP at 0x20 and the values 3, 0x50 and 0x109 in words 1 to 3, ends with word 0 and AC equal to 3, SP equal to 0x20 and PC equal to 0x5A.
- R11: The memory write enable is never asserted while halted and is never asserted in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Leave the halted state and begin fetching |
| halted | output | 1 | High while the core is stopped |
| dbgLoadPc | input | 1 | Load PC from dbgData while halted |
| dbgLoadSp | input | 1 | Load SP from dbgData while halted |
| dbgLoadAc | input | 1 | Load AC from dbgData while halted |
| dbgData | input | 16 | Value for the debug loads |
| pcOut | output | 12 | Current program counter |
| spOut | output | 16 | Current stack pointer |
| acOut | output | 16 | Current accumulator |
| memAddr | output | 12 | Word address to memory |
| memWdata | output | 16 | Write data to memory |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 16 | Read data, valid one cycle after the address |

## Verification
The debug preload and the start pulse can land in the same clock edge, and the core must then fetch from the freshly loaded PC rather than the old one. The bench drives a PC load and `start` together toward a word holding a halt instruction and judges the PC left after the halt, which is one past the loaded address only if the preload took effect before the first fetch. A second collision, debug loads asserted while a program is running, is judged by the AC and SP values the program leaves behind.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 12;
  localparam int NIB_W  = 4;
  localparam int IMM_W  = 8;

  typedef enum logic [2:0] {
    ST_HALT, ST_FETCH, ST_DEC, ST_ADDR, ST_EXEC, ST_WB2
  } stateT;

  typedef enum logic [2:0] {
    AS_PC, AS_X, AS_SPX, AS_SP, AS_SPM1, AS_AC
  } addrSelT;

  typedef enum logic [1:0] { WD_AC, WD_PC, WD_TMP } wdSelT;

  typedef enum logic [2:0] {
    AO_HOLD, AO_LOAD_RD, AO_ADD_RD, AO_SUB_RD, AO_LOAD_X, AO_FROM_SP, AO_DBG
  } acOpT;

  typedef enum logic [2:0] {
    SO_HOLD, SO_INC, SO_DEC, SO_ADD_IMM, SO_SUB_IMM, SO_FROM_AC, SO_DBG
  } spOpT;

  typedef enum logic [2:0] {
    PO_HOLD, PO_INC, PO_LOAD_X, PO_LOAD_RD, PO_DBG
  } pcOpT;

  typedef enum logic [4:0] {
    K_LDDIR, K_STDIR, K_ADDDIR, K_SUBDIR, K_BRPOS, K_BRZERO, K_BRALW, K_LDCONST,
    K_LDLOC, K_STLOC, K_ADDLOC, K_SUBLOC, K_BRNEG, K_BRNZ, K_CALL,
    K_PUSHIND, K_POPIND, K_PUSH, K_POP, K_RET, K_XCHG, K_SPUP, K_SPDN, K_STOP
  } kindT;

  typedef struct packed {
    pcOpT    pcOp;
    spOpT    spOp;
    acOpT    acOp;
    logic    irLoad;
    logic    tmpLoad;
    addrSelT addrSel;
    wdSelT   wdSel;
    logic    we;
  } strobeT;

  function automatic kindT decodeWord(input logic [WORD_W-1:0] w);
    logic lowZero;
    kindT k;
    lowZero = (w[IMM_W-1:0] == '0);
    k = K_STOP;
    case (w[WORD_W-1 -: NIB_W])
      4'h0: k = K_LDDIR;
      4'h1: k = K_STDIR;
      4'h2: k = K_ADDDIR;
      4'h3: k = K_SUBDIR;
      4'h4: k = K_BRPOS;
      4'h5: k = K_BRZERO;
      4'h6: k = K_BRALW;
      4'h7: k = K_LDCONST;
      4'h8: k = K_LDLOC;
      4'h9: k = K_STLOC;
      4'hA: k = K_ADDLOC;
      4'hB: k = K_SUBLOC;
      4'hC: k = K_BRNEG;
      4'hD: k = K_BRNZ;
      4'hE: k = K_CALL;
      default: begin
        case (w[WORD_W-NIB_W-1 -: NIB_W])
          4'h0: k = lowZero ? K_PUSHIND : K_STOP;
          4'h2: k = lowZero ? K_POPIND  : K_STOP;
          4'h4: k = lowZero ? K_PUSH    : K_STOP;
          4'h6: k = lowZero ? K_POP     : K_STOP;
          4'h8: k = lowZero ? K_RET     : K_STOP;
          4'hA: k = lowZero ? K_XCHG    : K_STOP;
          4'hC: k = K_SPUP;
          4'hE: k = K_SPDN;
          default: k = K_STOP;
        endcase
      end
    endcase
    return k;
  endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dbgLoadPc,
  input  logic              dbgLoadSp,
  input  logic              dbgLoadAc,
  input  logic [WORD_W-1:0] ir,
  input  logic              acZero,
  input  logic              acNeg,
  output strobeT            stb,
  output logic              halted
);

  stateT state, nextState;
  kindT  kind;

  assign kind   = decodeWord(ir);
  assign halted = (state == ST_HALT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HALT;
    else       state <= nextState;
  end

  always_comb begin
    stb.pcOp    = PO_HOLD;
    stb.spOp    = SO_HOLD;
    stb.acOp    = AO_HOLD;
    stb.irLoad  = 1'b0;
    stb.tmpLoad = 1'b0;
    stb.addrSel = AS_PC;
    stb.wdSel   = WD_AC;
    stb.we      = 1'b0;
    nextState   = state;
    case (state)
      ST_HALT: begin
        if (dbgLoadPc) stb.pcOp = PO_DBG;
        if (dbgLoadSp) stb.spOp = SO_DBG;
        if (dbgLoadAc) stb.acOp = AO_DBG;
        if (start) nextState = ST_FETCH;
      end
      ST_FETCH: begin
        stb.addrSel = AS_PC;
        stb.pcOp    = PO_INC;
        nextState   = ST_DEC;
      end
      ST_DEC: begin
        stb.irLoad = 1'b1;
        nextState  = ST_ADDR;
      end
      ST_ADDR: begin
        nextState = ST_FETCH;
        case (kind)
          K_LDDIR, K_ADDDIR, K_SUBDIR: begin
            stb.addrSel = AS_X;
            nextState   = ST_EXEC;
          end
          K_STDIR: begin
            stb.addrSel = AS_X;
            stb.wdSel   = WD_AC;
            stb.we      = 1'b1;
          end
          K_LDLOC, K_ADDLOC, K_SUBLOC: begin
            stb.addrSel = AS_SPX;
            nextState   = ST_EXEC;
          end
          K_STLOC: begin
            stb.addrSel = AS_SPX;
            stb.wdSel   = WD_AC;
            stb.we      = 1'b1;
          end
          K_BRPOS:  if (!acNeg)  stb.pcOp = PO_LOAD_X;
          K_BRZERO: if (acZero)  stb.pcOp = PO_LOAD_X;
          K_BRALW:  stb.pcOp = PO_LOAD_X;
          K_BRNEG:  if (acNeg)   stb.pcOp = PO_LOAD_X;
          K_BRNZ:   if (!acZero) stb.pcOp = PO_LOAD_X;
          K_LDCONST: stb.acOp = AO_LOAD_X;
          K_CALL: begin
            stb.addrSel = AS_SPM1;
            stb.wdSel   = WD_PC;
            stb.we      = 1'b1;
            stb.spOp    = SO_DEC;
            stb.pcOp    = PO_LOAD_X;
          end
          K_PUSH: begin
            stb.addrSel = AS_SPM1;
            stb.wdSel   = WD_AC;
            stb.we      = 1'b1;
            stb.spOp    = SO_DEC;
          end
          K_PUSHIND: begin
            stb.addrSel = AS_AC;
            nextState   = ST_EXEC;
          end
          K_POPIND, K_POP, K_RET: begin
            stb.addrSel = AS_SP;
            nextState   = ST_EXEC;
          end
          K_XCHG: begin
            stb.acOp = AO_FROM_SP;
            stb.spOp = SO_FROM_AC;
          end
          K_SPUP: stb.spOp = SO_ADD_IMM;
          K_SPDN: stb.spOp = SO_SUB_IMM;
          default: nextState = ST_HALT;
        endcase
      end
      ST_EXEC: begin
        nextState = ST_FETCH;
        case (kind)
          K_LDDIR, K_LDLOC:   stb.acOp = AO_LOAD_RD;
          K_ADDDIR, K_ADDLOC: stb.acOp = AO_ADD_RD;
          K_SUBDIR, K_SUBLOC: stb.acOp = AO_SUB_RD;
          K_POP: begin
            stb.acOp = AO_LOAD_RD;
            stb.spOp = SO_INC;
          end
          K_RET: begin
            stb.pcOp = PO_LOAD_RD;
            stb.spOp = SO_INC;
          end
          K_POPIND: begin
            stb.tmpLoad = 1'b1;
            stb.spOp    = SO_INC;
            nextState   = ST_WB2;
          end
          K_PUSHIND: begin
            stb.tmpLoad = 1'b1;
            nextState   = ST_WB2;
          end
          default: ;
        endcase
      end
      ST_WB2: begin
        nextState = ST_FETCH;
        stb.wdSel = WD_TMP;
        stb.we    = 1'b1;
        if (kind == K_PUSHIND) begin
          stb.addrSel = AS_SPM1;
          stb.spOp    = SO_DEC;
        end else begin
          stb.addrSel = AS_AC;
        end
      end
      default: nextState = ST_HALT;
    endcase
  end

endmodule

// File: rtl/stk_dpath.sv
module stk_dpath
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [WORD_W-1:0] dbgData,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWe,
  output logic [WORD_W-1:0] ir,
  output logic              acZero,
  output logic              acNeg,
  output logic [ADDR_W-1:0] pcOut,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] acOut
);

  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] sp, ac, tmp;
  logic [ADDR_W-1:0] opnd;
  logic [WORD_W-1:0] imm;

  assign opnd = ir[ADDR_W-1:0];
  assign imm  = {{(WORD_W-IMM_W){1'b0}}, ir[IMM_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= '0;
      sp  <= '0;
      ac  <= '0;
      ir  <= '0;
      tmp <= '0;
    end else begin
      if (stb.irLoad)  ir  <= memRdata;
      if (stb.tmpLoad) tmp <= memRdata;

      case (stb.pcOp)
        PO_INC:     pc <= pc + 1'b1;
        PO_LOAD_X:  pc <= opnd;
        PO_LOAD_RD: pc <= memRdata[ADDR_W-1:0];
        PO_DBG:     pc <= dbgData[ADDR_W-1:0];
        default:    ;
      endcase

      case (stb.spOp)
        SO_INC:     sp <= sp + 1'b1;
        SO_DEC:     sp <= sp - 1'b1;
        SO_ADD_IMM: sp <= sp + imm;
        SO_SUB_IMM: sp <= sp - imm;
        SO_FROM_AC: sp <= ac;
        SO_DBG:     sp <= dbgData;
        default:    ;
      endcase

      case (stb.acOp)
        AO_LOAD_RD: ac <= memRdata;
        AO_ADD_RD:  ac <= ac + memRdata;
        AO_SUB_RD:  ac <= ac - memRdata;
        AO_LOAD_X:  ac <= {{(WORD_W-ADDR_W){1'b0}}, opnd};
        AO_FROM_SP: ac <= sp;
        AO_DBG:     ac <= dbgData;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (stb.addrSel)
      AS_X:    memAddr = opnd;
      AS_SPX:  memAddr = sp[ADDR_W-1:0] + opnd;
      AS_SP:   memAddr = sp[ADDR_W-1:0];
      AS_SPM1: memAddr = sp[ADDR_W-1:0] - 1'b1;
      AS_AC:   memAddr = ac[ADDR_W-1:0];
      default: memAddr = pc;
    endcase
    case (stb.wdSel)
      WD_PC:   memWdata = {{(WORD_W-ADDR_W){1'b0}}, pc};
      WD_TMP:  memWdata = tmp;
      default: memWdata = ac;
    endcase
  end

  assign memWe  = stb.we;
  assign acZero = (ac == '0);
  assign acNeg  = ac[WORD_W-1];
  assign pcOut  = pc;
  assign spOut  = sp;
  assign acOut  = ac;

endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              halted,
  input  logic              dbgLoadPc,
  input  logic              dbgLoadSp,
  input  logic              dbgLoadAc,
  input  logic [WORD_W-1:0] dbgData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] acOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWe,
  input  logic [WORD_W-1:0] memRdata
);

  strobeT            stb;
  logic [WORD_W-1:0] ir;
  logic              acZero, acNeg;

  stk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .dbgLoadPc(dbgLoadPc), .dbgLoadSp(dbgLoadSp), .dbgLoadAc(dbgLoadAc),
    .ir(ir), .acZero(acZero), .acNeg(acNeg),
    .stb(stb), .halted(halted)
  );

  stk_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dbgData(dbgData),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .ir(ir), .acZero(acZero), .acNeg(acNeg),
    .pcOut(pcOut), .spOut(spOut), .acOut(acOut)
  );

endmodule

// File: rtl/stk_core_checker.sv
module stk_core_checker
  import stk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              halted,
  input logic              dbgLoadPc,
  input logic [ADDR_W-1:0] pcOut,
  input logic              memWe
);

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (halted && start) |=> !halted); // R2

  AST_HALT_PC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !start && !dbgLoadPc) |=> (pcOut == $past(pcOut))); // R2

  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWe); // R11

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe); // R11

endmodule

bind stk_core stk_core_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .halted(halted),
  .dbgLoadPc(dbgLoadPc), .pcOut(pcOut), .memWe(memWe)
);

// File: tb/stk_core_bench.sv
module stk_core_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rstN, start, halted;
  logic        dbgLoadPc, dbgLoadSp, dbgLoadAc;
  logic [15:0] dbgData;
  logic [11:0] pcOut, memAddr;
  logic [15:0] spOut, acOut, memWdata, memRdata;
  logic        memWe;

  stk_core u_stk_core (
    .clk(clk), .rstN(rstN), .start(start), .halted(halted),
    .dbgLoadPc(dbgLoadPc), .dbgLoadSp(dbgLoadSp), .dbgLoadAc(dbgLoadAc),
    .dbgData(dbgData), .pcOut(pcOut), .spOut(spOut), .acOut(acOut),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata)
  );

  logic [15:0] mem [0:4095];
  logic        tbWe;
  logic [11:0] tbAddr;
  logic [15:0] tbData;

  always @(posedge clk) begin
    if (tbWe)       mem[tbAddr]  <= tbData;
    else if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk); tbWe = 1'b0;
  endtask

  task automatic setRegs(input logic [15:0] pc, input logic [15:0] sp, input logic [15:0] ac);
    @(negedge clk); dbgData = pc; dbgLoadPc = 1'b1;
    @(negedge clk); dbgLoadPc = 1'b0; dbgData = sp; dbgLoadSp = 1'b1;
    @(negedge clk); dbgLoadSp = 1'b0; dbgData = ac; dbgLoadAc = 1'b1;
    @(negedge clk); dbgLoadAc = 1'b0;
  endtask

  task automatic waitHalt(input string req);
    int n = 0;
    while (!halted && n < 20000) begin @(negedge clk); n++; end
    if (!halted) begin
      checks++; errors++;
      $display("FAIL %s actual=running expected=halted", req);
    end
  endtask

  task automatic run(input string req);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitHalt(req);
  endtask

  function automatic logic brTaken(input logic [3:0] op, input logic [15:0] a);
    case (op)
      4'h4: return !a[15];
      4'h5: return a == 16'h0;
      4'h6: return 1'b1;
      4'hC: return a[15];
      default: return a != 16'h0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    logic [3:0]  brOps [5];
    logic [15:0] acVals [5];
    logic [15:0] aVals [5];
    logic [15:0] bVals [5];
    logic [15:0] spVals [3];
    brOps  = '{4'h4, 4'h5, 4'h6, 4'hC, 4'hD};
    acVals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    aVals  = '{16'h0005, 16'hFFFF, 16'h8000, 16'h1234, 16'h0000};
    bVals  = '{16'h0003, 16'h0001, 16'h8000, 16'h4321, 16'h0001};
    spVals = '{16'h0FF8, 16'hF005, 16'h1FFB};

    rstN = 1'b0; start = 1'b0; tbWe = 1'b0; tbAddr = '0; tbData = '0;
    dbgLoadPc = 1'b0; dbgLoadSp = 1'b0; dbgLoadAc = 1'b0; dbgData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 halted", {15'b0, halted}, 16'h1);
    check("R1 pc", {4'h0, pcOut}, 16'h0);
    check("R1 sp", spOut, 16'h0);
    check("R1 ac", acOut, 16'h0);

    // R10 minimum of three
    poke(12'h001, 16'h0003); poke(12'h002, 16'h0050); poke(12'h003, 16'h0109);
    poke(12'h050, 16'h0001); poke(12'h051, 16'hF400); poke(12'h052, 16'h0002);
    poke(12'h053, 16'hF400); poke(12'h054, 16'h0003); poke(12'h055, 16'hF400);
    poke(12'h056, 16'hE100); poke(12'h057, 16'hFC03); poke(12'h058, 16'h1000);
    poke(12'h059, 16'hFFFF);
    poke(12'h100, 16'h8001); poke(12'h101, 16'hB002); poke(12'h102, 16'hC105);
    poke(12'h103, 16'h8002); poke(12'h104, 16'h9001); poke(12'h105, 16'h8001);
    poke(12'h106, 16'hB003); poke(12'h107, 16'hC10A); poke(12'h108, 16'h8003);
    poke(12'h109, 16'hF800); poke(12'h10A, 16'h8001); poke(12'h10B, 16'hF800);
    setRegs(16'h0050, 16'h0020, 16'h0000);
    run("R10");
    check("R10 word0", mem[0], 16'h0003);
    check("R10 ac", acOut, 16'h0003);
    check("R10 sp", spOut, 16'h0020);
    check("R10 pc", {4'h0, pcOut}, 16'h005A);
    check("R6 call return address", mem[12'h01C], 16'h0057);

    // R4 branch sweep
    poke(12'h001, 16'hFFFF);
    poke(12'h010, 16'hFFFF);
    for (int i = 0; i < 5; i++) begin
      poke(12'h000, {brOps[i], 12'h010});
      for (int j = 0; j < 5; j++) begin
        setRegs(16'h0000, 16'h0100, acVals[j]);
        run("R4");
        check($sformatf("R4 op=%h ac=%h", brOps[i], acVals[j]), {4'h0, pcOut},
              brTaken(brOps[i], acVals[j]) ? 16'h0011 : 16'h0002);
      end
    end

    // R3 direct arithmetic sweep
    poke(12'h501, 16'hFFFF);
    for (int i = 0; i < 5; i++) begin
      poke(12'h200, bVals[i]);
      poke(12'h500, 16'h2200);
      setRegs(16'h0500, 16'h0100, aVals[i]);
      run("R3");
      check("R3 add", acOut, aVals[i] + bVals[i]);
      poke(12'h500, 16'h3200);
      setRegs(16'h0500, 16'h0100, aVals[i]);
      run("R3");
      check("R3 sub", acOut, aVals[i] - bVals[i]);
      poke(12'h500, 16'h0200);
      setRegs(16'h0500, 16'h0100, 16'hDEAD);
      run("R3");
      check("R3 load", acOut, bVals[i]);
    end
    poke(12'h500, 16'h7ABC);
    setRegs(16'h0500, 16'h0100, 16'hFFFF);
    run("R3");
    check("R3 constant zero-extend", acOut, 16'h0ABC);
    poke(12'h500, 16'h1210);
    setRegs(16'h0500, 16'h0100, 16'hBEEF);
    run("R3");
    check("R3 store", mem[12'h210], 16'hBEEF);

    // R5 local addressing with wrap
    poke(12'h008, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      logic [11:0] off;
      off = 12'h008 - spVals[i][11:0];
      poke(12'h500, {4'h9, off});
      setRegs(16'h0500, spVals[i], 16'hCA00 + 16'(i));
      run("R5");
      check("R5 store local", mem[12'h008], 16'hCA00 + 16'(i));
      poke(12'h500, {4'h8, off});
      setRegs(16'h0500, spVals[i], 16'h0000);
      run("R5");
      check("R5 load local", acOut, 16'hCA00 + 16'(i));
      poke(12'h500, {4'hA, off});
      setRegs(16'h0500, spVals[i], 16'h0100);
      run("R5");
      check("R5 add local", acOut, 16'hCB00 + 16'(i));
      poke(12'h500, {4'hB, off});
      setRegs(16'h0500, spVals[i], 16'h0000);
      run("R5");
      check("R5 sub local", acOut, 16'h0000 - (16'hCA00 + 16'(i)));
    end

    // R6 push / pop
    poke(12'h600, 16'hF400); poke(12'h601, 16'h7000);
    poke(12'h602, 16'hF600); poke(12'h603, 16'hFFFF);
    setRegs(16'h0600, 16'h0040, 16'h1111);
    run("R6");
    check("R6 pushed word", mem[12'h03F], 16'h1111);
    check("R6 pop ac", acOut, 16'h1111);
    check("R6 pop sp", spOut, 16'h0040);

    // R7 indirect push / pop
    poke(12'h220, 16'hA5A5); poke(12'h230, 16'h0000);
    poke(12'h610, 16'hF000); poke(12'h611, 16'h7230);
    poke(12'h612, 16'hF200); poke(12'h613, 16'hFFFF);
    setRegs(16'h0610, 16'h0050, 16'h0220);
    run("R7");
    check("R7 indirect push word", mem[12'h04F], 16'hA5A5);
    check("R7 indirect pop target", mem[12'h230], 16'hA5A5);
    check("R7 sp restored", spOut, 16'h0050);

    // R8 exchange and sp adjust
    poke(12'h620, 16'hFA00); poke(12'h621, 16'hFC05);
    poke(12'h622, 16'hFEFF); poke(12'h623, 16'hFFFF);
    setRegs(16'h0620, 16'h0010, 16'h1234);
    run("R8");
    check("R8 ac after exchange", acOut, 16'h0010);
    check("R8 sp after adjust", spOut, 16'h1234 + 16'h0005 - 16'h00FF);

    // R9 undecodable words halt
    poke(12'h630, 16'hF100);
    setRegs(16'h0630, 16'h0040, 16'h0077);
    run("R9");
    check("R9 pc after F100", {4'h0, pcOut}, 16'h0631);
    poke(12'h640, 16'hF401);
    setRegs(16'h0640, 16'h0040, 16'h0077);
    run("R9");
    check("R9 pc after F401", {4'h0, pcOut}, 16'h0641);
    check("R9 sp untouched", spOut, 16'h0040);
    check("R9 no push written", mem[12'h03F], 16'h1111);

    // R2 preload together with start
    poke(12'h300, 16'hFFFF);
    @(negedge clk); dbgData = 16'h0300; dbgLoadPc = 1'b1; start = 1'b1;
    @(negedge clk); dbgLoadPc = 1'b0; start = 1'b0;
    waitHalt("R2");
    check("R2 same-cycle preload", {4'h0, pcOut}, 16'h0301);

    // R2 debug loads while running are ignored
    for (int k = 0; k < 8; k++) poke(12'h400 + 12'(k), 16'h7005);
    poke(12'h408, 16'hFFFF);
    setRegs(16'h0400, 16'h0030, 16'h0077);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    dbgData = 16'h1234; dbgLoadAc = 1'b1; dbgLoadSp = 1'b1;
    @(negedge clk); dbgLoadAc = 1'b0; dbgLoadSp = 1'b0;
    waitHalt("R2");
    check("R2 ac ignores running load", acOut, 16'h0005);
    check("R2 sp ignores running load", spOut, 16'h0030);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule